// File: doc/BRIEF.md
# Push-Button Qualifier and Capture

This block sits between four push-button lines and a transmit sequencer. Each raw line is first brought into the clock domain through a short flop chain. A qualification counter then counts sample ticks for as long as at least one button is held. The counter restarts from zero whenever every button reads inactive. When the counter reaches its window length, the block raises a one-cycle wake pulse and loads a 4-bit data word. That word is the OR of every button seen since qualification began, so near-simultaneous presses are merged into one word.

After a capture the block holds the word and ignores all button activity until the sequencer asserts its done input. With the default 1 ms tick and a window of 8 ticks, presses shorter than about 8 ms never reach the sequencer. The window length must be at least 2 ticks.

The controller has three states:
- `ST_IDLE`: no button active.
- `ST_QUAL`: qualifying.
- `ST_HELD`: word frozen, waiting for the sequencer.

Its transitions are:
- `ST_IDLE` to `ST_QUAL` on any synchronized button active.
- `ST_QUAL` to `ST_IDLE` when all buttons read inactive.
- `ST_QUAL` to `ST_HELD` when the counter expires. The wake pulse fires on this transition.
- `ST_HELD` to `ST_IDLE` on done.

Top module: `btn_capture`

## Requirements
- R1: Each raw button passes through SYNC_STAGES (default 2) flops before filtering. With `tick_i` held high, `wake_o` is first seen high after WIN_TICKS+2 rising edges, counting from the first edge at which a press is present.
- R2: `wake_o` rises only after WIN_TICKS tick cycles in which at least one synchronized button was active, with no fully inactive cycle between them. A press spanning fewer ticks produces no wake. `wake_o` follows a cycle with `tick_i` high.
- R3: A single cycle with all synchronized buttons inactive during qualification clears both the tick count and the collected button mask. A later press must then fill a fresh window, and only its own buttons are captured.
- R4: Bit i of `word_o` reflects button line i. The captured word is the OR of all synchronized button states seen from the start of qualification up to and including the capturing cycle. Any combination of the four bits, including all four, can be captured.
- R5: `wake_o` is high for exactly one clock cycle per capture. `word_o` takes its new value in that same cycle.
- R6: `word_o` changes only in a cycle where `wake_o` is high. Buttons pressed after the capture, or held beyond it, do not alter it.
- R7: From the capture until `seq_done_i` is seen, no further wake occurs, whatever the buttons do.
- R8: `seq_done_i` in the held state returns the block to idle with a cleared count. A button still held then needs a full new window before it wakes the block again. With `tick_i` held high, the new wake is seen WIN_TICKS+1 edges after the done edge. `seq_done_i` outside the held state has no effect.
- R9: While `rst_n` is low, `wake_o` is 0 and `word_o` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle sample tick that times the qualification window |
| btn_raw_i | input | 4 | Raw active-high button lines, bit i is button i |
| seq_done_i | input | 1 | Sequencer reports the transmission set is finished |
| wake_o | output | 1 | One-cycle wake/start pulse on a qualified press |
| word_o | output | 4 | Frozen button word from the most recent capture |

## Verification
The bench builds the block with WIN_TICKS set to 4 and the default two-stage synchronizer, so a window fits in a handful of tick periods. It drives the tick directly, either every second cycle or continuously. The short window brings several corners within a few dozen cycles: presses one tick short of the window, a second button joining on exactly the capturing tick, restarts after a one-period release, and holds lasting twice the window. Continuous ticking pins down the exact latency through the synchronizer and counter, both after a fresh press and after a done with the button still held.

// File: rtl/btncap_pkg.sv
package btncap_pkg;
    localparam int BTN_COUNT = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_HELD = 2'd2
    } cap_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    // one independent flop chain per button line
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
                end
            end
            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/win_counter.sv
module win_counter #(
    parameter int WIN_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic expire_o
);
    localparam int CW = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = inc_i && !clr_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || expire_o) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < WIN_TICKS);
endmodule

// File: rtl/capture_fsm.sv
module capture_fsm
    import btncap_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] btn_i,
    input  logic             expire_i,
    input  logic             done_i,
    output logic             cnt_clr_o,
    output logic             wake_o,
    output logic [WIDTH-1:0] word_o
);
    cap_state_e       state_q, state_d;
    logic [WIDTH-1:0] mask_q;
    logic             any_act;

    assign any_act   = |btn_i;
    assign cnt_clr_o = !any_act || (state_q == ST_HELD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_act)       state_d = ST_QUAL;
            ST_QUAL: if (!any_act)      state_d = ST_IDLE;
                     else if (expire_i) state_d = ST_HELD;
            ST_HELD: if (done_i)        state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs: collected mask, wake pulse, frozen word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            wake_o <= 1'b0;
            word_o <= '0;
        end else begin
            wake_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: mask_q <= any_act ? btn_i : '0;
                ST_QUAL: begin
                    if (!any_act) begin
                        mask_q <= '0;
                    end else if (expire_i) begin
                        word_o <= mask_q | btn_i;
                        wake_o <= 1'b1;
                        mask_q <= '0;
                    end else begin
                        mask_q <= mask_q | btn_i;
                    end
                end
                ST_HELD: mask_q <= '0;
                default: mask_q <= '0;
            endcase
        end
    end

    // R5
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R6
    word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> $stable(word_o));

    // R7
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(state_q) != ST_HELD));
endmodule

// File: rtl/btn_capture.sv
module btn_capture
    import btncap_pkg::*;
#(
    parameter int WIN_TICKS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [BTN_COUNT-1:0] btn_raw_i,
    input  logic                 seq_done_i,
    output logic                 wake_o,
    output logic [BTN_COUNT-1:0] word_o
);
    logic [BTN_COUNT-1:0] btn_s;
    logic                 cnt_clr;
    logic                 expire;
    logic                 cnt_inc;

    btn_sync #(
        .WIDTH (BTN_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (btn_raw_i),
        .sync_o(btn_s)
    );

    assign cnt_inc = tick_i && (|btn_s);

    win_counter #(
        .WIN_TICKS(WIN_TICKS)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .expire_o(expire)
    );

    capture_fsm #(
        .WIDTH(BTN_COUNT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_i    (btn_s),
        .expire_i (expire),
        .done_i   (seq_done_i),
        .cnt_clr_o(cnt_clr),
        .wake_o   (wake_o),
        .word_o   (word_o)
    );

    // R2
    wake_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(tick_i));
endmodule

// File: tb/btn_capture_test.sv
module btn_capture_test;
    localparam int W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] btn_raw = 4'h0;
    logic       done = 1'b0;
    logic       wake_o;
    logic [3:0] word_o;

    int checks = 0;
    int errors = 0;
    int wake_cnt = 0;
    logic [3:0] cap_word = 4'h0;
    logic wake_prev = 1'b0;
    bit finished = 0;

    btn_capture #(.WIN_TICKS(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_raw_i(btn_raw),
        .seq_done_i(done), .wake_o(wake_o), .word_o(word_o)
    );

    always #10 clk = ~clk;

    // observe outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wake_o) begin
                wake_cnt++;
                cap_word = word_o;
                if (wake_prev) begin
                    checks++; errors++;
                    $display("FAIL R5 wake width actual 2+ expected 1");
                end
            end
            wake_prev = wake_o;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] b, input logic t, input logic d);
        btn_raw = b; tick = t; done = d;
        @(negedge clk);
    endtask

    task automatic run(input logic [3:0] m, input int periods);
        for (int p = 0; p < periods; p++) begin
            cyc(m, 1'b1, 1'b0);
            cyc(m, 1'b0, 1'b0);
        end
    endtask

    // {mask1, periods1, gap periods, mask2, periods2, expect wake, expect word}
    typedef struct packed {
        logic [3:0] m1; logic [7:0] k1; logic [7:0] gap;
        logic [3:0] m2; logic [7:0] k2; logic ew; logic [3:0] ewd;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'b0001, 8'd6, 8'd0, 4'b0000, 8'd0, 1'b1, 4'b0001},  // R2 long
        '{4'b0010, 8'd3, 8'd0, 4'b0000, 8'd0, 1'b0, 4'b0000},  // R2 short
        '{4'b0001, 8'd2, 8'd0, 4'b0101, 8'd3, 1'b1, 4'b0101},  // R4 merge
        '{4'b1000, 8'd1, 8'd0, 4'b1010, 8'd1, 1'b0, 4'b0000},  // R2 short merge
        '{4'b0100, 8'd3, 8'd1, 4'b0010, 8'd4, 1'b1, 4'b0010},  // R3 restart
        '{4'b0011, 8'd3, 8'd2, 4'b1000, 8'd3, 1'b0, 4'b0000},  // R3 no wake
        '{4'b1111, 8'd4, 8'd0, 4'b0000, 8'd0, 1'b1, 4'b1111},  // R4 all
        '{4'b0001, 8'd3, 8'd0, 4'b1001, 8'd1, 1'b1, 4'b1001},  // R4 last tick
        '{4'b0110, 8'd8, 8'd0, 4'b0000, 8'd0, 1'b1, 4'b0110},  // R7 long hold
        '{4'b0001, 8'd4, 8'd0, 4'b0011, 8'd3, 1'b1, 4'b0001}   // R6 late press
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [3:0] held;
        int base;
        int n;
        held = 4'h0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 wake in reset", int'(wake_o), 0);
        check("R9 word in reset", int'(word_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            base = wake_cnt;
            run(VECS[v].m1, int'(VECS[v].k1));
            run(4'h0, int'(VECS[v].gap));
            run(VECS[v].m2, int'(VECS[v].k2));
            run(4'h0, 3);
            check($sformatf("R2/R7 vector %0d wake count", v),
                  wake_cnt - base, int'(VECS[v].ew));
            if (VECS[v].ew) begin
                held = VECS[v].ewd;
                check($sformatf("R4 vector %0d captured word", v),
                      int'(cap_word), int'(held));
            end
            check($sformatf("R6 vector %0d held word", v), int'(word_o), int'(held));
            cyc(4'h0, 1'b0, 1'b1);
            run(4'h0, 2);
        end

        // R1 latency with continuous ticking
        base = wake_cnt;
        n = 0;
        btn_raw = 4'b0100; tick = 1'b1;
        while (n < 40 && !wake_o) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check("R1 edges to wake", n, W + 2);
        check("R5 word with wake", int'(word_o), 4'b0100);

        // R6 R7 noise while held
        for (int i = 0; i < 6; i++) cyc(4'b1011 ^ 4'(i), 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) cyc(4'b0110, 1'b1, 1'b0);
        check("R7 no wake while held", wake_cnt - base, 1);
        check("R6 word frozen while held", int'(word_o), 4'b0100);

        // R8 done with button still held: full new window
        btn_raw = 4'b0110; tick = 1'b1; done = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk);
        done = 1'b0;
        while (n < 40 && !wake_o) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check("R8 edges to requalify", n, W + 1);
        check("R8 new word", int'(word_o), 4'b0110);
        run(4'h0, 3);
        cyc(4'h0, 1'b0, 1'b1);
        run(4'h0, 2);

        // R8 stray done in idle has no effect
        base = wake_cnt;
        cyc(4'h0, 1'b1, 1'b1);
        run(4'h0, 4);
        check("R8 stray done no wake", wake_cnt - base, 0);
        check("R8 stray done word kept", int'(word_o), 4'b0110);
        run(4'b1000, 3);
        run(4'h0, 2);
        check("R2 short press after stray done", wake_cnt - base, 0);
        run(4'b1000, 4);
        run(4'h0, 2);
        check("R2 full press after stray done", wake_cnt - base, 1);
        check("R4 word bit3", int'(word_o), 4'b1000);

        finish_run();
    end
endmodule